// File: doc/BRIEF.md
# ADC power mode controller

This block is the power sequencing logic of a serially controlled sampling converter. A frame begins when chip select goes low. The serial clock idles high, so the first edge inside a frame is a falling one. A frame completes on its sixteenth rising edge. The serial clock edges reach the block as single-cycle pulses in the system clock domain. The shift logic outside the block supplies the power-mode and reference bits decoded from the control byte of the current frame. The block holds them as its control state from the moment the frame completes.

From that state and the frame edges, the block drives an enable for the converter core and an enable for the internal reference. A ready flag rises once a wake-up delay, counted in system clocks, has elapsed after the core is enabled. There are two such delays: a long one when the reference must come up too, and a short one when the reference was already stable.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After synchronous reset the mode state is 00 (normal), the reference bit is 0, and `core_en`, `ref_en` and `ready` are all 1.
- R2: `cfg_mode` and `cfg_ref_off` are taken into the control state only at the 16th `sclk_rise` while `cs_n` is low, and appear on `mode_state` the next cycle. Serial edges while `cs_n` is high are ignored.
- R3: With mode 00 (normal) written, `core_en` is 1 from the cycle after the frame's 16th rising edge and stays 1 across later frames.
- R4: With mode 01 (full shutdown) written, `core_en` and `ref_en` are 0 from the cycle after the 16th rising edge. They stay 0 through later frames until a frame writes 00; `core_en` returns the cycle after that frame's 16th rising edge.
- R5: With mode 10 (auto shutdown), core and reference go off after each frame's 16th rising edge and come back on the cycle after the first falling edge of the next frame. When 10 is written from full shutdown, the block stays down until that next frame.
- R6: With mode 11 (auto standby), the core powers down and up at the same edges as in mode 10, while `ref_en` stays 1 throughout (reference bit 0).
- R7: The reference bit is active low: when it is 1, `ref_en` is 0 in every mode.
- R8: `ready` is 0 while `core_en` is 0. It rises exactly `WAKE_SD_CYC` cycles after `core_en` rises. It rises after `WAKE_SB_CYC` cycles instead when, just before the wake, the mode state was 11 or the reference bit was 1.
- R9: A rise of `cs_n` before the 16th rising edge ends the frame with no control update and no power-down, and the next frame counts from its first edge.
- R10: With `cs_n` held low, the edge after the 16th rising edge starts a new frame; its first falling edge wakes an automatic mode, and its 16th rising edge updates the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low during a frame |
| sclk_rise | input | 1 | One-cycle pulse per rising serial clock edge |
| sclk_fall | input | 1 | One-cycle pulse per falling serial clock edge |
| cfg_mode | input | 2 | Power mode decoded from the current frame's control byte |
| cfg_ref_off | input | 1 | Reference bit from the current control byte, 1 disables the reference |
| core_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Internal reference power enable |
| ready | output | 1 | Core enabled and wake-up delay elapsed |
| mode_state | output | 2 | Power mode currently held in the control state |

## Verification
Every control and power change is registered at the system clock edge that carries the serial edge pulse. The bench therefore samples `mode_state`, `core_en` and `ref_en` on the falling system clock edge right after the pulse is dropped, one cycle after the stimulus. The `ready` flag is due a wake-delay count of cycles after `core_en` rises. The bench checks it low one cycle before that count and high exactly at it, for both the slow and the fast delay. Ignored and aborted stimulus is judged by sampling `mode_state` and `core_en` after the would-be trigger, before any further frame.

// File: rtl/adc_pwr_pkg.sv
// Shared types for the ADC power mode controller.
// Holds the encoding of the two-bit power mode field.
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_FULL_SD = 2'b01,
        PM_AUTO_SD = 2'b10,
        PM_AUTO_SB = 2'b11
    } pm_mode_e;

endpackage

// File: rtl/frame_edge_counter.sv
// Tracks the serial frame: counts rising edges while chip select is low,
// flags the frame's 16th (FRAME_LEN-th) rising edge and its first falling edge.
// Assumes sclk_rise and sclk_fall are one-cycle pulses and never coincide.
module frame_edge_counter #(
    parameter int FRAME_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic frame_done,
    output logic first_fall
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] edge_cnt;
    logic             fall_seen;

    // Completion and first-fall strobes, valid only inside a frame
    always_comb begin
        frame_done = !cs_n && sclk_rise && (edge_cnt == LAST);
        first_fall = !cs_n && sclk_fall && !fall_seen;
    end

    // Rising-edge count and first-fall memory; cleared outside a frame or on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt  <= '0;
            fall_seen <= 1'b0;
        end else if (cs_n) begin
            edge_cnt  <= '0;
            fall_seen <= 1'b0;
        end else begin
            if (sclk_rise)
                edge_cnt <= frame_done ? '0 : edge_cnt + 1'b1;
            if (frame_done)
                fall_seen <= 1'b0;
            else if (sclk_fall)
                fall_seen <= 1'b1;
        end
    end

    // R9
    cs_abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (edge_cnt == '0 && !fall_seen));

    // R10
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (edge_cnt == '0 && !fall_seen));

endmodule

// File: rtl/pwr_mode_fsm.sv
// Holds the control state (mode and reference bit) and the core power state.
// Control state loads at frame completion. Automatic modes sleep at completion
// and wake at the first falling edge of the next frame.
// Assumes frame_done and first_fall never coincide.
module pwr_mode_fsm
    import adc_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_done,
    input  logic       first_fall,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_ref_off,
    output logic [1:0] mode_out,
    output logic       core_on,
    output logic       ref_on,
    output logic       power_up,
    output logic       fast_wake
);
    pm_mode_e mode_q;
    logic     ref_off_q;
    logic     core_nx;
    logic     auto_mode;

    // Next core power state from frame events and the held mode
    always_comb begin
        auto_mode = (mode_q == PM_AUTO_SD) || (mode_q == PM_AUTO_SB);
        core_nx   = core_on;
        if (frame_done)
            core_nx = (pm_mode_e'(cfg_mode) == PM_NORMAL);
        else if (first_fall && auto_mode)
            core_nx = 1'b1;
    end

    // Derived outputs: wake strobe, wake speed, reference enable
    always_comb begin
        power_up  = core_nx && !core_on;
        fast_wake = (mode_q == PM_AUTO_SB) || ref_off_q;
        ref_on    = !ref_off_q && (core_on || mode_q == PM_AUTO_SB);
        mode_out  = mode_q;
    end

    // Control state and core power register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= PM_NORMAL;
            ref_off_q <= 1'b0;
            core_on   <= 1'b1;
        end else begin
            core_on <= core_nx;
            if (frame_done) begin
                mode_q    <= pm_mode_e'(cfg_mode);
                ref_off_q <= cfg_ref_off;
            end
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(mode_q) && $stable(ref_off_q)));

    // R4
    full_sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_FULL_SD && !frame_done) |=> !core_on);

    // R3
    normal_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_NORMAL) |-> core_on);

endmodule

// File: rtl/wake_timer.sv
// Counts the wake-up delay in system clocks after the core is enabled and
// reports ready once it has elapsed. Assumes both delays are at least 1.
module wake_timer #(
    parameter int WAKE_SD_CYC = 1000,
    parameter int WAKE_SB_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_on,
    input  logic power_up,
    input  logic fast_wake,
    output logic ready
);
    localparam int MAX_CYC = (WAKE_SD_CYC > WAKE_SB_CYC) ? WAKE_SD_CYC : WAKE_SB_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] wait_cnt;

    // Load the selected delay on wake, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_cnt <= '0;
        else if (power_up)
            wait_cnt <= fast_wake ? CNT_W'(WAKE_SB_CYC) : CNT_W'(WAKE_SD_CYC);
        else if (wait_cnt != '0)
            wait_cnt <= wait_cnt - 1'b1;
    end

    // Ready once powered and the count is spent
    always_comb ready = core_on && (wait_cnt == '0);

    // R8
    wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_up |=> !ready);

endmodule

// File: rtl/adc_pwr_ctrl.sv
// Top of the ADC power mode controller: frame tracking, mode state and
// wake-up timing. Inputs are synchronous to clk; serial edges arrive as pulses.
module adc_pwr_ctrl #(
    parameter int FRAME_LEN   = 16,
    parameter int WAKE_SD_CYC = 1000,
    parameter int WAKE_SB_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_ref_off,
    output logic       core_en,
    output logic       ref_en,
    output logic       ready,
    output logic [1:0] mode_state
);
    logic frame_done;
    logic first_fall;
    logic power_up;
    logic fast_wake;

    frame_edge_counter #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .frame_done (frame_done),
        .first_fall (first_fall)
    );

    pwr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .first_fall  (first_fall),
        .cfg_mode    (cfg_mode),
        .cfg_ref_off (cfg_ref_off),
        .mode_out    (mode_state),
        .core_on     (core_en),
        .ref_on      (ref_en),
        .power_up    (power_up),
        .fast_wake   (fast_wake)
    );

    wake_timer #(.WAKE_SD_CYC(WAKE_SD_CYC), .WAKE_SB_CYC(WAKE_SB_CYC)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .core_on   (core_en),
        .power_up  (power_up),
        .fast_wake (fast_wake),
        .ready     (ready)
    );

    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> ($past(first_fall) || $past(frame_done)));

    // R8
    ready_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_en) |-> !ready);

endmodule

// File: tb/adc_pwr_ctrl_bench.sv
// Self-checking bench: vector table of frames, then directed tests.
module adc_pwr_ctrl_bench;
    localparam int SD = 60;
    localparam int SB = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk_rise = 1'b0;
    logic sclk_fall = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic cfg_ref_off = 1'b0;
    logic core_en, ref_en, ready;
    logic [1:0] mode_state;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    adc_pwr_ctrl #(.FRAME_LEN(16), .WAKE_SD_CYC(SD), .WAKE_SB_CYC(SB)) u_adc_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .cfg_mode(cfg_mode), .cfg_ref_off(cfg_ref_off),
        .core_en(core_en), .ref_en(ref_en), .ready(ready), .mode_state(mode_state)
    );

    // {mode, ref bit, core/ref after first fall, core/ref/mode after frame}
    localparam logic [8:0] VEC [13] = '{
        9'b00_0_11_11_00, 9'b10_0_11_00_10, 9'b10_0_11_00_10, 9'b11_0_11_01_11,
        9'b11_1_11_00_11, 9'b01_0_10_00_01, 9'b01_0_00_00_01, 9'b10_0_00_00_10,
        9'b10_0_11_00_10, 9'b01_0_11_00_01, 9'b00_0_00_11_00, 9'b00_1_11_10_00,
        9'b00_0_10_11_00
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fall_pulse();
        @(negedge clk) sclk_fall = 1'b1;
        @(negedge clk) sclk_fall = 1'b0;
    endtask

    task automatic rise_pulse();
        @(negedge clk) sclk_rise = 1'b1;
        @(negedge clk) sclk_rise = 1'b0;
    endtask

    task automatic frame_start();
        @(negedge clk) cs_n = 1'b0;
        fall_pulse();
    endtask

    // Remaining 15 falls and 16 rises, control byte on the inputs
    task automatic frame_rest(input logic [1:0] m, input logic r);
        cfg_mode = m;
        cfg_ref_off = r;
        for (int i = 0; i < 16; i++) begin
            rise_pulse();
            if (i < 15) fall_pulse();
        end
    endtask

    task automatic frame_end();
        @(negedge clk) cs_n = 1'b1;
    endtask

    function automatic string req_of(input logic [1:0] m, input logic r);
        if (r) return "R7";
        case (m)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(mode_state), 0);
        chk("R1 core", int'(core_en), 1);
        chk("R1 ref", int'(ref_en), 1);
        chk("R1 ready", int'(ready), 1);

        // R2 edges with chip select high are ignored
        cfg_mode = 2'b01;
        for (int i = 0; i < 20; i++) begin
            rise_pulse();
            fall_pulse();
        end
        chk("R2 mode", int'(mode_state), 0);
        chk("R2 core", int'(core_en), 1);

        // Vector table of full frames
        for (int v = 0; v < 13; v++) begin
            logic [8:0] e;
            string rq;
            e = VEC[v];
            rq = req_of(e[8:7], e[6]);
            frame_start();
            chk({rq, " core after first fall"}, int'(core_en), int'(e[5]));
            chk({rq, " ref after first fall"}, int'(ref_en), int'(e[4]));
            frame_rest(e[8:7], e[6]);
            chk({rq, " core after frame"}, int'(core_en), int'(e[3]));
            chk({rq, " ref after frame"}, int'(ref_en), int'(e[2]));
            chk({rq, " mode after frame"}, int'(mode_state), int'(e[1:0]));
            frame_end();
        end

        // R9 abort: sleep in mode 10, wake, then abort mid-frame writing 01
        frame_start();
        frame_rest(2'b10, 1'b0);
        frame_end();
        frame_start();
        cfg_mode = 2'b01;
        for (int i = 0; i < 5; i++) begin
            rise_pulse();
            fall_pulse();
        end
        frame_end();
        @(negedge clk);
        chk("R9 mode kept", int'(mode_state), 2);
        chk("R9 core kept", int'(core_en), 1);
        // R9 next frame counts from its first edge
        frame_start();
        frame_rest(2'b10, 1'b0);
        chk("R9 recount core", int'(core_en), 0);
        frame_end();

        // R8 slow wake from auto shutdown
        chk("R8 ready low asleep", int'(ready), 0);
        frame_start();
        chk("R8 core woke", int'(core_en), 1);
        for (int k = 1; k < SD; k++) @(negedge clk);
        chk("R8 slow not yet", int'(ready), 0);
        @(negedge clk);
        chk("R8 slow ready", int'(ready), 1);
        frame_rest(2'b11, 1'b0);
        frame_end();
        chk("R8 ready low standby", int'(ready), 0);

        // R8 fast wake from auto standby
        frame_start();
        for (int k = 1; k < SB; k++) @(negedge clk);
        chk("R8 fast not yet", int'(ready), 0);
        @(negedge clk);
        chk("R8 fast ready", int'(ready), 1);
        frame_rest(2'b00, 1'b0);
        frame_end();

        // R10 back-to-back frames with chip select held low
        frame_start();
        frame_rest(2'b10, 1'b0);
        chk("R10 first frame sleep", int'(core_en), 0);
        fall_pulse();
        chk("R10 second frame wake", int'(core_en), 1);
        frame_rest(2'b00, 1'b1);
        chk("R10 second frame mode", int'(mode_state), 0);
        chk("R10 second frame ref", int'(ref_en), 0);
        frame_end();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule